// File: doc/BRIEF.md
# Bit-Sliced ALU with Hex Digit Output

This block is a small arithmetic-logic unit whose width is a parameter (three bits by default). It is built as a chain of identical one-bit slices. Each slice has its own copy of the operand conditioning. An operand bit is forced to zero when its enable is low. The A bit may then be inverted. A two-bit function code then selects AND, OR, the complement of B, or a full add. In add mode the carry passes from each slice to the next, starting from the carry input.

The carry-out and the result together form a four-bit value, with the carry-out as the most significant bit. This value goes to a hexadecimal seven-segment decoder, which drives one display digit. The whole unit is combinational. Outputs follow the inputs within the same cycle and hold no state.

Top module: `bitslice_alu_disp`

## Requirements
- R1: With func_i = 2'b00 the result is A' AND B'. Here A' = (ena_i ? a_i : 0) XOR {WIDTH{inva_i}} and B' = (enb_i ? b_i : 0).
- R2: With func_i = 2'b01 the result is A' OR B'.
- R3: With func_i = 2'b10 the result is NOT B'. a_i, ena_i and inva_i have no effect on it.
- R4: With func_i = 2'b11, {cout_o, result_o} equals A' + B' + cin_i.
- R5: With func_i other than 2'b11, cout_o is 0 and cin_i has no effect on any output.
- R6: When ena_i is low, operand A is zero before inversion. With inva_i high the operand is then all ones.
- R7: When enb_i is low, operand B is zero in every function.
- R8: seg_o shows the value {cout_o, result_o}. It is active high, with seg_o[0] = segment a up to seg_o[6] = segment g. The codes for 0 to F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R9: The carry ripples through every slice. For example, A' = all ones, B' = 0 and cin_i = 1 gives a result of 0 with cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ena_i | input | 1 | Operand A enable |
| enb_i | input | 1 | Operand B enable |
| inva_i | input | 1 | Invert operand A after gating |
| func_i | input | 2 | Function code |
| cin_i | input | 1 | Carry into slice 0 |
| result_o | output | WIDTH | Function result |
| cout_o | output | 1 | Carry out of the top slice |
| seg_o | output | 7 | Segment pattern, a in bit 0 |

## Verification
The block has no registers, so a fault in one slice's gating, inversion or carry logic shows at the ports in the same cycle as the stimulus. Such a fault appears as a wrong result bit at that slice's position, or as a carry error that reaches every higher bit and the digit. The sweep covers every operand, control and function combination. A fault that only shows under one pairing, such as inversion of a disabled operand or a full-length carry chain, is therefore reached on the first pass.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic opa;
        logic opb;
        logic and_r;
        logic or_r;
        logic notb_r;
        logic sum_r;
        logic carry_r;
    } slice_res_t;

    localparam int SEG_W   = 7;
    localparam int DIGIT_W = 4;

    function automatic logic [SEG_W-1:0] hex_glyph(input logic [DIGIT_W-1:0] v);
        logic [SEG_W-1:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import bitslice_alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    ena_i,
    input  logic    enb_i,
    input  logic    inva_i,
    input  alu_fn_e fn_i,
    input  logic    cin_i,
    output logic    y_o,
    output logic    cout_o
);

    slice_res_t res_d;

    // Operand conditioning and every candidate result of this bit
    always_comb begin
        res_d        = '0;
        res_d.opa    = (a_i & ena_i) ^ inva_i;
        res_d.opb    = b_i & enb_i;
        res_d.and_r  = res_d.opa & res_d.opb;
        res_d.or_r   = res_d.opa | res_d.opb;
        res_d.notb_r = ~res_d.opb;
        res_d.sum_r  = res_d.opa ^ res_d.opb ^ cin_i;
        res_d.carry_r = (res_d.opa & res_d.opb)
                      | ((res_d.opa ^ res_d.opb) & cin_i);
    end

    // Function select as a multiplexer over the candidates
    always_comb begin
        y_o    = 1'b0;
        cout_o = 1'b0;
        case (fn_i)
            FN_AND:  y_o = res_d.and_r;
            FN_OR:   y_o = res_d.or_r;
            FN_NOTB: y_o = res_d.notb_r;
            default: begin
                y_o    = res_d.sum_r;
                cout_o = res_d.carry_r;
            end
        endcase
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ena_i,
    input  logic             enb_i,
    input  logic             inva_i,
    input  alu_fn_e          fn_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] y_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .ena_i  (ena_i),
            .enb_i  (enb_i),
            .inva_i (inva_i),
            .fn_i   (fn_i),
            .cin_i  (carry_d[i]),
            .y_o    (y_o[i]),
            .cout_o (carry_d[i+1])
        );
    end

    assign cout_o = carry_d[WIDTH];

endmodule

// File: rtl/hex_digit_dec.sv
module hex_digit_dec
    import bitslice_alu_pkg::*;
#(
    parameter int VAL_W = 4
) (
    input  logic [VAL_W-1:0] val_i,
    output logic [SEG_W-1:0] seg_o
);

    logic [DIGIT_W-1:0] nib_d;

    if (VAL_W == DIGIT_W) begin : g_exact
        assign nib_d = val_i;
    end else if (VAL_W < DIGIT_W) begin : g_pad
        assign nib_d = {{(DIGIT_W-VAL_W){1'b0}}, val_i};
    end else begin : g_trunc
        assign nib_d = val_i[DIGIT_W-1:0];
    end

    always_comb begin
        seg_o = hex_glyph(nib_d);
    end

endmodule

// File: rtl/bitslice_alu_disp.sv
module bitslice_alu_disp
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ena_i,
    input  logic             enb_i,
    input  logic             inva_i,
    input  logic [1:0]       func_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] result_o,
    output logic             cout_o,
    output logic [6:0]       seg_o
);

    localparam int DISP_W = WIDTH + 1;

    alu_fn_e          fn_d;
    logic [WIDTH-1:0] y_d;
    logic             co_d;
    logic [DISP_W-1:0] disp_d;

    always_comb begin
        fn_d   = alu_fn_e'(func_i);
        disp_d = {co_d, y_d};
    end

    alu_ripple #(.WIDTH(WIDTH)) u_ripple (
        .a_i    (a_i),
        .b_i    (b_i),
        .ena_i  (ena_i),
        .enb_i  (enb_i),
        .inva_i (inva_i),
        .fn_i   (fn_d),
        .cin_i  (cin_i),
        .y_o    (y_d),
        .cout_o (co_d)
    );

    hex_digit_dec #(.VAL_W(DISP_W)) u_digit (
        .val_i (disp_d),
        .seg_o (seg_o)
    );

    assign result_o = y_d;
    assign cout_o   = co_d;

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 3
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             ena_i,
    input logic             enb_i,
    input logic             inva_i,
    input logic [1:0]       func_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] result_o,
    input logic             cout_o,
    input logic [6:0]       seg_o
);

    logic [WIDTH-1:0] ref_a;
    logic [WIDTH-1:0] ref_b;
    logic [WIDTH:0]   ref_sum;
    logic             known;

    always_comb begin
        known   = !$isunknown({a_i, b_i, ena_i, enb_i, inva_i, func_i, cin_i});
        ref_a   = (ena_i ? a_i : '0) ^ {WIDTH{inva_i}};
        ref_b   = enb_i ? b_i : '0;
        ref_sum = {1'b0, ref_a} + {1'b0, ref_b} + {{WIDTH{1'b0}}, cin_i};
        if (known) begin
            if (func_i == 2'b00) AST_AND_RESULT: assert (result_o == (ref_a & ref_b)); // R1
            if (func_i == 2'b01) AST_OR_RESULT: assert (result_o == (ref_a | ref_b)); // R2
            if (func_i == 2'b10) AST_NOTB_RESULT: assert (result_o == ~ref_b); // R3
            if (func_i == 2'b11) AST_ADD_SUM: assert ({cout_o, result_o} == ref_sum); // R4
            if (func_i != 2'b11) AST_LOGIC_NO_CARRY: assert (cout_o == 1'b0); // R5
            AST_SEG_LIT: assert (seg_o != 7'h00); // R8
        end
    end

endmodule

bind bitslice_alu_disp bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .ena_i    (ena_i),
    .enb_i    (enb_i),
    .inva_i   (inva_i),
    .func_i   (func_i),
    .cin_i    (cin_i),
    .result_o (result_o),
    .cout_o   (cout_o),
    .seg_o    (seg_o)
);

// File: tb/bitslice_alu_disp_bench.sv
module bitslice_alu_disp_bench;

    localparam int W = 3;

    logic         clk = 1'b0;
    logic [W-1:0] a_i, b_i;
    logic         ena_i, enb_i, inva_i, cin_i;
    logic [1:0]   func_i;
    logic [W-1:0] result_o;
    logic         cout_o;
    logic [6:0]   seg_o;

    int  n_run  = 0;
    int  n_fail = 0;
    int  cycles = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    bitslice_alu_disp #(.WIDTH(W)) u_bitslice_alu_disp (
        .a_i      (a_i),
        .b_i      (b_i),
        .ena_i    (ena_i),
        .enb_i    (enb_i),
        .inva_i   (inva_i),
        .func_i   (func_i),
        .cin_i    (cin_i),
        .result_o (result_o),
        .cout_o   (cout_o),
        .seg_o    (seg_o)
    );

    function automatic logic [6:0] glyph(input int v);
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
            12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (a=%0d b=%0d ena=%0b enb=%0b inva=%0b f=%0d cin=%0b)",
                     tag, act, exp, a_i, b_i, ena_i, enb_i, inva_i, func_i, cin_i);
        end
    endtask

    task automatic apply(input int a, input int b, input int ea, input int eb,
                         input int ia, input int f, input int c);
        @(negedge clk);
        a_i = W'(a); b_i = W'(b); ena_i = ea[0]; enb_i = eb[0];
        inva_i = ia[0]; func_i = f[1:0]; cin_i = c[0];
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int oa, ob, er, ec;
        // Idle input state: all zero, AND -> 0, digit 0
        apply(0, 0, 0, 0, 0, 0, 0);
        check("R1 idle result", int'(result_o), 0);
        check("R8 idle seg", int'(seg_o), 7'h3F);

        // Exhaustive sweep
        for (int f = 0; f < 4; f++)
        for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
        for (int ea = 0; ea < 2; ea++)
        for (int eb = 0; eb < 2; eb++)
        for (int ia = 0; ia < 2; ia++)
        for (int c = 0; c < 2; c++) begin
            apply(a, b, ea, eb, ia, f, c);
            oa = (ea != 0) ? a : 0;
            if (ia != 0) oa = oa ^ 7;
            ob = (eb != 0) ? b : 0;
            ec = 0;
            case (f)
                0: er = oa & ob;
                1: er = oa | ob;
                2: er = (~ob) & 7;
                default: begin
                    er = (oa + ob + c) & 7;
                    ec = (oa + ob + c) >> 3;
                end
            endcase
            case (f)
                0: check("R1 and", int'(result_o), er);
                1: check("R2 or", int'(result_o), er);
                2: check("R3 notb", int'(result_o), er);
                default: check("R4 sum", int'(result_o), er);
            endcase
            if (f == 3) check("R4 carry", int'(cout_o), ec);
            else        check("R5 no carry", int'(cout_o), 0);
            check("R8 seg", int'(seg_o), int'(glyph(ec * 8 + er)));
        end

        // Directed boundary cases
        apply(5, 6, 0, 1, 1, 0, 0);
        check("R6 disabled A inverted", int'(result_o), 6);
        apply(7, 6, 0, 1, 0, 1, 0);
        check("R6 disabled A zero", int'(result_o), 6);
        apply(7, 5, 1, 0, 0, 1, 1);
        check("R7 disabled B", int'(result_o), 7);
        apply(2, 5, 1, 0, 0, 2, 0);
        check("R7 notb disabled", int'(result_o), 7);
        apply(7, 0, 1, 1, 0, 3, 1);
        check("R9 full ripple result", int'(result_o), 0);
        check("R9 full ripple carry", int'(cout_o), 1);
        check("R9 full ripple seg", int'(seg_o), 7'h7F);
        apply(7, 7, 1, 1, 0, 0, 1);
        check("R5 cin ignored cout", int'(cout_o), 0);
        check("R5 cin ignored result", int'(result_o), 7);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule